// File: doc/BRIEF.md
# Audio Amplifier Reset Sequencer

This block is the start-up controller for a six-channel PWM audio modulator. A low level on the active-low reset pin forces every output that reaches the power stage into a safe level straight away, without waiting for a clock edge. The safe outputs are the per-channel valid lines, the PWM half-bridge drives, the forwarded master clock and the clip flag. The same low level holds the modulator in hard mute and at full attenuation, and tells the control and serial-audio ports to ignore their traffic.

Release is handled more carefully. The reset is brought into the reference-clock domain through a two-stage deassertion synchronizer. A watchdog samples the master clock and decides whether it is alive. If the power-down pin allows it, an initialization runs for a fixed number of master-clock rising edges, about 4.5 ms at the nominal rate. When that finishes, hard mute is lifted on a clock edge and a soft volume ramp is requested from the volume logic. During initialization the block reloads the default configuration: volume, clock ratio, master/slave mode, auto-mute, de-emphasis, DC offset and the staggered per-channel delays.

The sequencer states are named as follows:
- HOLD: reset is asserted or not yet synchronized.
- STBY: power-down is low, so the block waits muted.
- WCLK: the block waits for a live master clock.
- INIT: the initialization counter runs.
- RAMP: a volume ramp has been requested.
- RUN: normal operation.

The transitions are:
- HOLD goes to STBY, WCLK or INIT once the synchronized reset is released.
- STBY goes to WCLK or INIT when power-down rises.
- WCLK goes to INIT when the clock watchdog reports a live clock.
- INIT goes back to WCLK if the clock is lost, and on to RAMP on the last counted edge.
- RAMP goes to RUN on ramp completion.
- Every state after HOLD goes to STBY when power-down falls.

Top module: `audio_rst_seq`

## Requirements
- R1: While `rst_n` is low, and without any clock edge, `valid_o`, `pwm_p_o`, `pwm_m_o` and `mclk_o` are all 0 and `clip_o` is 1.
- R2: While `rst_n` is low, `hard_mute_o`, `vol_full_atten_o` and `bus_ignore_o` are 1 and `ramp_req_o` is 0.
- R3: While `rst_n` is low, `ser_clk_low_o` equals `ms_sel_i` (1 means master mode, so the clock pins are pulled low; 0 means slave mode, so the pins stay inputs) and `ser_clk_en_o` is 0.
- R4: Initialization lasts exactly INIT_EDGES master-clock rising edges. After that `ramp_req_o` rises and stays high until `ramp_done_i` is seen. Then the block runs, with `valid_o` all ones and the PWM inputs passed through.
- R5: If the master clock is idle when reset is released, the initialization count does not start, and `ramp_req_o` stays low until the clock becomes live.
- R6: If the master clock is lost during initialization, the sequencer returns to waiting and the edge count restarts from zero.
- R7: Hard mute is released only on a reference-clock edge, at the moment initialization completes, and it is re-applied whenever the sequencer leaves RAMP/RUN.
- R8: Initialization loads these values:
  - `cfg_vol_o` = 0 (0 dB)
  - `cfg_ratio_o` = 256
  - `cfg_master_o` = `ms_sel_i`
  - `cfg_automute_o` = 1
  - `cfg_deemph_o` = 0 (off)
  - `cfg_dc_ofs_o` = 0
- R9: The delay for channel i is held in bits [8i+7:8i] of `cfg_ch_delay_o` and equals 16·i, so each channel is 16 clocks behind the one before it.
- R10: When power-down is low (`pwr_up_i` = 0), the block sits in standby with hard mute on. A rising `pwr_up_i` starts the sequence, and a falling `pwr_up_i` at any point after release returns the block to standby.
- R11: The master clock counts as live from the cycle after a detected rising edge. It is declared dead after TIMEOUT reference cycles with no rising edge.
- R12: The release of `rst_n` passes through two synchronizer flops, so the sequencer leaves HOLD on the third reference-clock rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | Power-down pin, high = operate |
| ms_sel_i | input | 1 | Master (1) / slave (0) select |
| mclk_i | input | 1 | Master clock, sampled for activity |
| ramp_done_i | input | 1 | Volume logic reports ramp complete |
| clip_i | input | 1 | Clip flag from the modulator |
| pwm_p_i | input | NCH | Modulator P drives |
| pwm_m_i | input | NCH | Modulator M drives |
| valid_o | output | NCH | Per-channel valid |
| pwm_p_o | output | NCH | Gated P drives |
| pwm_m_o | output | NCH | Gated M drives |
| mclk_o | output | 1 | Forwarded master clock |
| clip_o | output | 1 | Clip flag, forced high in reset |
| hard_mute_o | output | 1 | Hard mute to the modulator |
| vol_full_atten_o | output | 1 | Force full attenuation, no ramp |
| bus_ignore_o | output | 1 | Control and serial buses ignored |
| ser_clk_low_o | output | 1 | Drive bit/word clock pins low |
| ser_clk_en_o | output | 1 | Master-mode bit/word clock generation enable |
| ramp_req_o | output | 1 | Soft volume ramp request |
| cfg_vol_o | output | 8 | Default volume code |
| cfg_ratio_o | output | 10 | Default master clock ratio |
| cfg_master_o | output | 1 | Latched master/slave mode |
| cfg_automute_o | output | 1 | Auto-mute enable |
| cfg_deemph_o | output | 2 | De-emphasis select |
| cfg_dc_ofs_o | output | 16 | DC offset |
| cfg_ch_delay_o | output | NCH*8 | Per-channel delays |

## Verification
The embedded properties check several rules on every cycle:
- the forced pin levels, mute and serial-clock levels while reset is low;
- that RAMP is entered only from INIT on a counted clock edge;
- that a lost clock during INIT sends the sequencer to WCLK;
- that power-down drops it into STBY;
- that the mode bit is captured during initialization.

Only the bench scenarios can show the full effect of timing. They demonstrate the exact initialization length, the three-edge release latency, and the restart of the count after a clock stall. They also show that a short clock stretch below the timeout changes nothing, and that the released outputs follow the PWM and clip inputs. The bench does this by comparing every output against its behavioural model on every cycle.

// File: rtl/ars_pkg.sv
package ars_pkg;
    typedef enum logic [2:0] {
        S_HOLD = 3'd0,
        S_STBY = 3'd1,
        S_WCLK = 3'd2,
        S_INIT = 3'd3,
        S_RAMP = 3'd4,
        S_RUN  = 3'd5
    } seq_state_t;

    localparam int VOL_W         = 8;
    localparam int RATIO_W       = 10;
    localparam int DEEMPH_W      = 2;
    localparam int DC_W          = 16;
    localparam int RATIO_DEFAULT = 256;
endpackage

// File: rtl/ars_reset_sync.sv
module ars_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= 1'b1;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign rst_sync_n = chain_q[STAGES-1];

    AST_SYNC_LOW_IN_RESET: assert property (@(posedge clk) !rst_n |-> !rst_sync_n)
        else $error("sync reset high during reset"); // R12
endmodule

// File: rtl/ars_clk_monitor.sv
module ars_clk_monitor #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_i,
    output logic rise_o,
    output logic alive_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [2:0]       smp_q;
    logic [CNT_W-1:0] idle_q;
    logic             alive_q;

    assign rise_o  = smp_q[1] & ~smp_q[2];
    assign alive_o = alive_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q   <= '0;
            idle_q  <= '0;
            alive_q <= 1'b0;
        end else begin
            smp_q <= {smp_q[1:0], mclk_i};
            if (rise_o) begin
                idle_q  <= '0;
                alive_q <= 1'b1;
            end else if (idle_q == CNT_W'(TIMEOUT - 1)) begin
                alive_q <= 1'b0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    AST_ALIVE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alive_q) |-> $past(rise_o))
        else $error("clock declared live without an edge"); // R11
    AST_TIMEOUT_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_o && idle_q == CNT_W'(TIMEOUT - 1)) |=> !alive_q)
        else $error("clock kept live past timeout"); // R11
endmodule

// File: rtl/ars_fsm.sv
module ars_fsm
    import ars_pkg::*;
#(
    parameter int INIT_EDGES = 110592
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up_i,
    input  logic alive_i,
    input  logic rise_i,
    input  logic ramp_done_i,
    output logic running_o,
    output logic ramp_req_o,
    output logic hold_o,
    output logic cfg_load_o
);
    localparam int CNT_W = $clog2(INIT_EDGES + 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] edge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HOLD;
            edge_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != S_INIT) edge_q <= '0;
            else if (rise_i)       edge_q <= edge_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HOLD: begin
                if (!pwr_up_i)     state_d = S_STBY;
                else if (!alive_i) state_d = S_WCLK;
                else               state_d = S_INIT;
            end
            S_STBY: begin
                if (pwr_up_i) state_d = alive_i ? S_INIT : S_WCLK;
            end
            S_WCLK: begin
                if (!pwr_up_i)    state_d = S_STBY;
                else if (alive_i) state_d = S_INIT;
            end
            S_INIT: begin
                if (!pwr_up_i)     state_d = S_STBY;
                else if (!alive_i) state_d = S_WCLK;
                else if (rise_i && edge_q == CNT_W'(INIT_EDGES - 1))
                                   state_d = S_RAMP;
            end
            S_RAMP: begin
                if (!pwr_up_i)       state_d = S_STBY;
                else if (ramp_done_i) state_d = S_RUN;
            end
            S_RUN: begin
                if (!pwr_up_i) state_d = S_STBY;
            end
            default: state_d = S_HOLD;
        endcase
    end

    always_comb begin
        running_o  = (state_q == S_RAMP) || (state_q == S_RUN);
        ramp_req_o = (state_q == S_RAMP);
        hold_o     = (state_q == S_HOLD);
        cfg_load_o = (state_q == S_INIT);
    end

    AST_RAMP_FROM_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_RAMP) |-> $past(state_q == S_INIT && rise_i))
        else $error("ramp entered without a counted edge"); // R7
    AST_RAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RAMP && pwr_up_i && !ramp_done_i) |=> state_q == S_RAMP)
        else $error("ramp request dropped early"); // R4
    AST_WAIT_NO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WCLK && !alive_i) |=> state_q != S_INIT)
        else $error("init started on dead clock"); // R5
    AST_LOSS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INIT && pwr_up_i && !alive_i) |=> state_q == S_WCLK)
        else $error("init kept running on dead clock"); // R6
    AST_PWRDN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_up_i && state_q != S_HOLD) |=> state_q == S_STBY)
        else $error("power-down ignored"); // R10
endmodule

// File: rtl/ars_defaults.sv
module ars_defaults
    import ars_pkg::*;
#(
    parameter int NCH      = 6,
    parameter int DLY_W    = 8,
    parameter int DLY_STEP = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load_i,
    input  logic                   ms_sel_i,
    output logic [VOL_W-1:0]       vol_o,
    output logic [RATIO_W-1:0]     ratio_o,
    output logic                   master_o,
    output logic                   automute_o,
    output logic [DEEMPH_W-1:0]    deemph_o,
    output logic [DC_W-1:0]        dc_ofs_o,
    output logic [NCH*DLY_W-1:0]   ch_delay_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vol_o      <= '0;
            ratio_o    <= RATIO_W'(RATIO_DEFAULT);
            master_o   <= 1'b0;
            automute_o <= 1'b1;
            deemph_o   <= '0;
            dc_ofs_o   <= '0;
        end else if (cfg_load_i) begin
            vol_o      <= '0;
            ratio_o    <= RATIO_W'(RATIO_DEFAULT);
            master_o   <= ms_sel_i;
            automute_o <= 1'b1;
            deemph_o   <= '0;
            dc_ofs_o   <= '0;
        end
    end

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_dly
            localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(ch * DLY_STEP);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          ch_delay_o[ch*DLY_W +: DLY_W] <= DLY_INIT;
                else if (cfg_load_i) ch_delay_o[ch*DLY_W +: DLY_W] <= DLY_INIT;
            end
        end
    endgenerate

    AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_i |=> master_o == $past(ms_sel_i))
        else $error("mode not captured"); // R8
endmodule

// File: rtl/audio_rst_seq.sv
module audio_rst_seq
    import ars_pkg::*;
#(
    parameter int NCH        = 6,
    parameter int INIT_EDGES = 110592,
    parameter int TIMEOUT    = 32,
    parameter int DLY_STEP   = 16,
    parameter int DLY_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_up_i,
    input  logic                 ms_sel_i,
    input  logic                 mclk_i,
    input  logic                 ramp_done_i,
    input  logic                 clip_i,
    input  logic [NCH-1:0]       pwm_p_i,
    input  logic [NCH-1:0]       pwm_m_i,
    output logic [NCH-1:0]       valid_o,
    output logic [NCH-1:0]       pwm_p_o,
    output logic [NCH-1:0]       pwm_m_o,
    output logic                 mclk_o,
    output logic                 clip_o,
    output logic                 hard_mute_o,
    output logic                 vol_full_atten_o,
    output logic                 bus_ignore_o,
    output logic                 ser_clk_low_o,
    output logic                 ser_clk_en_o,
    output logic                 ramp_req_o,
    output logic [VOL_W-1:0]     cfg_vol_o,
    output logic [RATIO_W-1:0]   cfg_ratio_o,
    output logic                 cfg_master_o,
    output logic                 cfg_automute_o,
    output logic [DEEMPH_W-1:0]  cfg_deemph_o,
    output logic [DC_W-1:0]      cfg_dc_ofs_o,
    output logic [NCH*DLY_W-1:0] cfg_ch_delay_o
);
    logic rst_sync_n, mclk_rise, mclk_alive;
    logic running, ramp_req, hold, cfg_load, live;

    ars_reset_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

    ars_clk_monitor #(.TIMEOUT(TIMEOUT)) u_mon (
        .clk(clk), .rst_n(rst_sync_n), .mclk_i(mclk_i),
        .rise_o(mclk_rise), .alive_o(mclk_alive));

    ars_fsm #(.INIT_EDGES(INIT_EDGES)) u_fsm (
        .clk(clk), .rst_n(rst_sync_n), .pwr_up_i(pwr_up_i),
        .alive_i(mclk_alive), .rise_i(mclk_rise), .ramp_done_i(ramp_done_i),
        .running_o(running), .ramp_req_o(ramp_req), .hold_o(hold),
        .cfg_load_o(cfg_load));

    ars_defaults #(.NCH(NCH), .DLY_W(DLY_W), .DLY_STEP(DLY_STEP)) u_cfg (
        .clk(clk), .rst_n(rst_sync_n), .cfg_load_i(cfg_load), .ms_sel_i(ms_sel_i),
        .vol_o(cfg_vol_o), .ratio_o(cfg_ratio_o), .master_o(cfg_master_o),
        .automute_o(cfg_automute_o), .deemph_o(cfg_deemph_o),
        .dc_ofs_o(cfg_dc_ofs_o), .ch_delay_o(cfg_ch_delay_o));

    assign live             = rst_n & running;
    assign valid_o          = {NCH{live}};
    assign pwm_p_o          = live ? pwm_p_i : '0;
    assign pwm_m_o          = live ? pwm_m_i : '0;
    assign mclk_o           = rst_n & mclk_i;
    assign clip_o           = ~rst_n | clip_i;
    assign hard_mute_o      = ~live;
    assign vol_full_atten_o = ~rst_n | hold;
    assign bus_ignore_o     = ~rst_n | hold;
    assign ser_clk_low_o    = ~rst_n & ms_sel_i;
    assign ser_clk_en_o     = live & cfg_master_o;
    assign ramp_req_o       = rst_n & ramp_req;

    AST_RST_PINS_SAFE: assert property (@(posedge clk)
        !rst_n |-> (valid_o == '0 && pwm_p_o == '0 && pwm_m_o == '0 && !mclk_o && clip_o))
        else $error("unsafe pins in reset"); // R1
    AST_RST_SILENT: assert property (@(posedge clk)
        !rst_n |-> (hard_mute_o && vol_full_atten_o && bus_ignore_o && !ramp_req_o))
        else $error("not silent in reset"); // R2
    AST_RST_SERCLK: assert property (@(posedge clk)
        !rst_n |-> (ser_clk_low_o == ms_sel_i && !ser_clk_en_o))
        else $error("serial clock pins wrong in reset"); // R3
endmodule

// File: tb/audio_rst_seq_tb_top.sv
`timescale 1ns/100ps
module audio_rst_seq_tb_top;
    localparam int NCH   = 6;
    localparam int IEDG  = 8;
    localparam int TMO   = 12;
    localparam int DLYW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pwr_up_i = 1'b1, ms_sel_i = 1'b1, mclk_i = 1'b0;
    logic ramp_done_i = 1'b0, clip_i = 1'b0;
    logic [NCH-1:0] pwm_p_i = '0, pwm_m_i = '0;
    logic [NCH-1:0] valid_o, pwm_p_o, pwm_m_o;
    logic mclk_o, clip_o, hard_mute_o, vol_full_atten_o, bus_ignore_o;
    logic ser_clk_low_o, ser_clk_en_o, ramp_req_o;
    logic [7:0] cfg_vol_o;
    logic [9:0] cfg_ratio_o;
    logic cfg_master_o, cfg_automute_o;
    logic [1:0] cfg_deemph_o;
    logic [15:0] cfg_dc_ofs_o;
    logic [NCH*DLYW-1:0] cfg_ch_delay_o;

    int errors = 0, checks = 0;
    bit mclk_run = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audio_rst_seq #(.NCH(NCH), .INIT_EDGES(IEDG), .TIMEOUT(TMO)) dut_i (.*);

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // master clock: toggles every 2 reference cycles while enabled
    int mdiv = 0;
    always @(negedge clk) begin
        if (mclk_run) begin
            mdiv++;
            if (mdiv == 2) begin mclk_i = ~mclk_i; mdiv = 0; end
        end
    end

    // modulator pattern and volume-ramp responder
    int pat = 0, rcnt = 0;
    always @(negedge clk) begin
        pat++;
        pwm_p_i = NCH'(pat);
        pwm_m_i = NCH'(pat * 7 + 3);
        clip_i  = pat[3];
        if (ramp_req_o === 1'b1) rcnt++; else rcnt = 0;
        ramp_done_i = (rcnt >= 3);
    end

    // behavioural model: 0 hold,1 standby,2 wait clock,3 init,4 ramp,5 run
    int  m_st = 0, m_cnt = 0, m_idle = 0;
    bit  m_alive = 0, m_s1 = 0, m_s2 = 0, m_master = 0;
    bit  m_hist[$] = '{0, 0, 0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_st = 0; m_cnt = 0; m_idle = 0;
            m_alive = 0; m_master = 0; m_hist = '{0, 0, 0};
        end else begin
            if (!m_s2) begin
                m_st = 0; m_cnt = 0; m_idle = 0; m_alive = 0; m_master = 0;
                m_hist = '{0, 0, 0};
            end else begin
                bit edge_seen;
                int nxt;
                edge_seen = m_hist[1] && !m_hist[2];
                nxt = m_st;
                if (m_st != 0 && !pwr_up_i) nxt = 1;
                else case (m_st)
                    0: nxt = m_alive ? 3 : 2;
                    1: nxt = m_alive ? 3 : 2;
                    2: if (m_alive) nxt = 3;
                    3: if (!m_alive) nxt = 2;
                       else if (edge_seen && m_cnt == IEDG - 1) nxt = 4;
                    4: if (ramp_done_i) nxt = 5;
                    default: ;
                endcase
                if (m_st == 3) m_master = ms_sel_i;
                if (m_st != 3) m_cnt = 0;
                else if (edge_seen) m_cnt++;
                if (edge_seen) begin m_idle = 0; m_alive = 1; end
                else if (m_idle == TMO - 1) m_alive = 0;
                else m_idle++;
                m_hist.push_front(mclk_i);
                void'(m_hist.pop_back());
                m_st = nxt;
            end
            m_s2 = m_s1;
            m_s1 = 1;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!done) begin
            bit live;
            logic [NCH*DLYW-1:0] dexp;
            live = rst_n && (m_st == 4 || m_st == 5);
            for (int i = 0; i < NCH; i++) dexp[i*DLYW +: DLYW] = DLYW'(16 * i);
            chk("R1 valid", 96'(valid_o), 96'(live ? {NCH{1'b1}} : '0));
            chk("R1 pwm", 96'({pwm_p_o, pwm_m_o}), 96'(live ? {pwm_p_i, pwm_m_i} : '0));
            chk("R1 mclk/clip", 96'({mclk_o, clip_o}), 96'({rst_n & mclk_i, ~rst_n | clip_i}));
            chk("R7 hard_mute", 96'(hard_mute_o), 96'(!live));
            chk(rst_n ? "R12 hold" : "R2 hold", 96'({vol_full_atten_o, bus_ignore_o}),
                96'({2{!rst_n || m_st == 0}}));
            chk("R3 serclk", 96'({ser_clk_low_o, ser_clk_en_o}),
                96'({!rst_n && ms_sel_i, live && m_master}));
            chk("R4 ramp_req", 96'(ramp_req_o), 96'(rst_n && m_st == 4));
            chk("R8 cfg", 96'({cfg_vol_o, cfg_ratio_o, cfg_master_o, cfg_automute_o,
                               cfg_deemph_o, cfg_dc_ofs_o}),
                96'({8'd0, 10'd256, m_master, 1'b1, 2'd0, 16'd0}));
            chk("R9 delays", 96'(cfg_ch_delay_o), 96'(dexp));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_run(input string tag);
        int k = 0;
        while (!(hard_mute_o === 1'b0 && ramp_req_o === 1'b0) && k < 2000) begin
            @(negedge clk); k++;
        end
        chk(tag, 96'(hard_mute_o), 96'(0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int t;
        cyc(5); #1;
        chk("R1 reset pins", 96'({valid_o, mclk_o, clip_o}), 96'({{NCH{1'b0}}, 1'b0, 1'b1}));
        chk("R3 master low", 96'(ser_clk_low_o), 96'(1));
        @(negedge clk); rst_n = 1'b1;
        // R12: hold lasts until third edge
        cyc(2); #1 chk("R12 still held", 96'(bus_ignore_o), 96'(1));
        wait_run("R4 reaches run");
        chk("R8 master", 96'(cfg_master_o), 96'(1));
        cyc(20);
        // R1: mid-cycle async assertion
        @(posedge clk); #1 rst_n = 1'b0; #0.5;
        chk("R1 async", 96'({valid_o, pwm_p_o, mclk_o, clip_o}),
            96'({{2*NCH{1'b0}}, 1'b0, 1'b1}));
        chk("R2 async", 96'({hard_mute_o, vol_full_atten_o, bus_ignore_o}), 96'(3'b111));
        // slave, idle clock
        @(negedge clk); ms_sel_i = 1'b0; mclk_run = 1'b0;
        cyc(3); #1 chk("R3 slave", 96'(ser_clk_low_o), 96'(0));
        @(negedge clk); rst_n = 1'b1;
        cyc(100); #1 chk("R5 idle waits", 96'({ramp_req_o, hard_mute_o}), 96'(2'b01));
        mclk_run = 1'b1;
        wait_run("R5 starts after clock");
        chk("R8 slave", 96'(cfg_master_o), 96'(0));
        // R11: short stretch below the timeout
        mclk_run = 1'b0; cyc(4); mclk_run = 1'b1; cyc(20);
        chk("R11 short stall", 96'(hard_mute_o), 96'(0));
        // R6: clock loss during init
        @(negedge clk); rst_n = 1'b0; ms_sel_i = 1'b1; cyc(3); rst_n = 1'b1;
        cyc(14); mclk_run = 1'b0;
        cyc(40); #1 chk("R6 muted while lost", 96'(hard_mute_o), 96'(1));
        mclk_run = 1'b1; t = 0;
        while (ramp_req_o !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
        chk("R6 full recount", 96'(t >= (IEDG - 1) * 4), 96'(1));
        wait_run("R6 reaches run");
        // R10: power-down at release
        @(negedge clk); rst_n = 1'b0; pwr_up_i = 1'b0; cyc(3); rst_n = 1'b1;
        cyc(60); #1 chk("R10 standby", 96'({hard_mute_o, ramp_req_o}), 96'(2'b10));
        @(negedge clk); pwr_up_i = 1'b1;
        wait_run("R10 start on rise");
        @(negedge clk); pwr_up_i = 1'b0;
        cyc(1); #1 chk("R10 drop to standby", 96'(hard_mute_o), 96'(1));
        @(negedge clk); pwr_up_i = 1'b1;
        wait_run("R10 restart");
        cyc(10);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule